// File: doc/BRIEF.md
# Block Transfer Stall Calculator

This unit works out the extra pipeline cycles that a multi-register block move costs. A block move transfers registers 0 through a last index L. It moves them to or from consecutive 32-bit words in memory, starting at a base address. The requester supplies five inputs: the base address, L, the direction, and two masks of recently written registers. The first mask covers the stage just before. The second covers the stage before that.

The unit returns three results:
- a hazard stall count, which applies only to stores;
- a line-crossing stall count, which follows from how many 32-byte cache lines the burst covers;
- for loads, the register mask that the hazard tracker should record both as freshly written and as block-load destinations.

It also raises an error flag when the burst wraps past the top of the address space, because then the span cannot be expressed. All results are computed combinationally and captured in one register stage. The data transfer itself happens elsewhere.

Top module: `xfer_stall_calc`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R2: Let the line number of an address be the address shifted right by 5. Let the end address be base + 4·(L+1) − 1, taken modulo 2^32. `straddle_stalls` is 0, 1 or 2 when the end line minus the base line is 0, 1 or 2. This holds for loads and for stores.
- R3: For a store, `hazard_stalls` is 2 when `mod_prev` has any bit set among bits 0..L.
- R4: For a store whose `mod_prev` has no bit set in 0..L, `hazard_stalls` is 1 when `mod_prev2` has any bit in 0..L, and 0 otherwise. Bits above L in either mask have no effect.
- R5: For a load (`req_is_store` = 0), `hazard_stalls` is 0 whatever the masks hold.
- R6: For a load, `load_mask` has exactly bits 0..L set. For a store, `load_mask` is 0.
- R7: Hazard and line-crossing stalls are reported separately, and neither reduces the other. For example, a store that hits `mod_prev` and covers three lines reports 2 and 2.
- R8: When the end address wraps below the base (line difference above 2), `span_error` is 1 and `straddle_stalls` is 0. Otherwise `span_error` is 0.
- R9: In a cycle without a request, the result fields keep their previous values.
- R10: After reset, `rsp_valid`, `hazard_stalls`, `straddle_stalls`, `span_error` and `load_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_is_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| req_base | input | 32 | Byte address of the first word |
| req_last | input | 4 | Last register index L |
| mod_prev | input | 16 | Registers written one stage back |
| mod_prev2 | input | 16 | Registers written two stages back |
| rsp_valid | output | 1 | Results valid for the previous cycle's request |
| hazard_stalls | output | 2 | Store source-hazard stall cycles |
| straddle_stalls | output | 2 | Cache-line crossing stall cycles |
| span_error | output | 1 | Burst wrapped the address space |
| load_mask | output | 16 | Registers to mark written for a load |

## Verification
All results pass through exactly one register. A request presented before a rising edge therefore shows on every output at that edge. The bench drives each request on a falling edge and checks all fields on the next falling edge, one full cycle later. An idle cycle then follows, with the address, index and masks changed. On the falling edge after it, the bench confirms that `rsp_valid` has dropped and that the fields still hold the earlier result.

// File: rtl/xfer_stall_pkg.sv
package xfer_stall_pkg;
  localparam int STALL_W = 2;
  typedef logic [STALL_W-1:0] stall_t;

  typedef enum logic [STALL_W-1:0] {
    HZ_NONE  = 2'd0,
    HZ_OLDER = 2'd1,
    HZ_NEWER = 2'd2
  } hazard_lvl_e;
endpackage

// File: rtl/xfer_span_calc.sv
module xfer_span_calc
  import xfer_stall_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int LINE_LOG2  = 5
) (
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [$clog2(NREG)-1:0]  last_idx,
  output stall_t                   straddle,
  output logic                     wrapped
);
  localparam int WB_LOG2    = $clog2(WORD_BYTES);
  localparam int LINE_BYTES = 1 << LINE_LOG2;
  localparam int MAX_EXTRA  = ((NREG * WORD_BYTES) - 1) / LINE_BYTES + 1;

  logic [ADDR_W-1:0] xfer_bytes;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W-1:0] line_diff;

  always_comb begin
    xfer_bytes = (ADDR_W'(last_idx) + ADDR_W'(1)) << WB_LOG2;
    end_addr   = base_addr + xfer_bytes - ADDR_W'(1);
    line_diff  = (end_addr >> LINE_LOG2) - (base_addr >> LINE_LOG2);
    wrapped    = line_diff > ADDR_W'(MAX_EXTRA);
    straddle   = wrapped ? stall_t'(0) : line_diff[STALL_W-1:0];
  end
endmodule

// File: rtl/xfer_reg_mask.sv
module xfer_reg_mask #(
  parameter int NREG = 16
) (
  input  logic [$clog2(NREG)-1:0] last_idx,
  output logic [NREG-1:0]         span_mask
);
  localparam int IDX_W = $clog2(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    assign span_mask[i] = (IDX_W'(i) <= last_idx);
  end
endmodule

// File: rtl/xfer_hazard_calc.sv
module xfer_hazard_calc
  import xfer_stall_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic            is_store,
  input  logic [NREG-1:0] span_mask,
  input  logic [NREG-1:0] wr_newer,
  input  logic [NREG-1:0] wr_older,
  output stall_t          hazard
);
  logic hit_newer;
  logic hit_older;

  always_comb begin
    hit_newer = |(span_mask & wr_newer);
    hit_older = |(span_mask & wr_older);
    if (!is_store)      hazard = stall_t'(HZ_NONE);
    else if (hit_newer) hazard = stall_t'(HZ_NEWER);
    else if (hit_older) hazard = stall_t'(HZ_OLDER);
    else                hazard = stall_t'(HZ_NONE);
  end
endmodule

// File: rtl/xfer_stall_calc.sv
module xfer_stall_calc
  import xfer_stall_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int LINE_LOG2  = 5,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IDX_W-1:0]  req_last,
  input  logic [NREG-1:0]   mod_prev,
  input  logic [NREG-1:0]   mod_prev2,
  output logic              rsp_valid,
  output logic [STALL_W-1:0] hazard_stalls,
  output logic [STALL_W-1:0] straddle_stalls,
  output logic              span_error,
  output logic [NREG-1:0]   load_mask
);
  logic [NREG-1:0] span_mask;
  stall_t          hz_nxt;
  stall_t          st_nxt;
  logic            err_nxt;
  logic [NREG-1:0] lmask_nxt;

  xfer_reg_mask #(.NREG(NREG)) u_mask (
    .last_idx  (req_last),
    .span_mask (span_mask)
  );

  xfer_span_calc #(
    .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES), .LINE_LOG2(LINE_LOG2)
  ) u_span (
    .base_addr (req_base),
    .last_idx  (req_last),
    .straddle  (st_nxt),
    .wrapped   (err_nxt)
  );

  xfer_hazard_calc #(.NREG(NREG)) u_hazard (
    .is_store  (req_is_store),
    .span_mask (span_mask),
    .wr_newer  (mod_prev),
    .wr_older  (mod_prev2),
    .hazard    (hz_nxt)
  );

  always_comb begin
    lmask_nxt = req_is_store ? '0 : span_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      hazard_stalls   <= '0;
      straddle_stalls <= '0;
      span_error      <= 1'b0;
      load_mask       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        hazard_stalls   <= hz_nxt;
        straddle_stalls <= st_nxt;
        span_error      <= err_nxt;
        load_mask       <= lmask_nxt;
      end
    end
  end
endmodule

// File: rtl/xfer_stall_calc_chk.sv
module xfer_stall_calc_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_is_store,
  input logic            rsp_valid,
  input logic [1:0]      hazard_stalls,
  input logic [1:0]      straddle_stalls,
  input logic            span_error,
  input logic [NREG-1:0] load_mask
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hazard_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> hazard_stalls != 2'd3);
  assert_load_no_hazard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_store) |=> hazard_stalls == 2'd0);
  assert_store_no_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_store) |=> load_mask == '0);
  assert_load_mask_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_store) |=> load_mask[0] && (((load_mask + 1'b1) & load_mask) == '0));
  assert_error_zero_straddle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    span_error |-> straddle_stalls == 2'd0);
  assert_straddle_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> straddle_stalls != 2'd3);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(load_mask) && $stable(hazard_stalls) &&
                    $stable(straddle_stalls) && $stable(span_error)));
endmodule

bind xfer_stall_calc xfer_stall_calc_chk #(.NREG(NREG)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_is_store    (req_is_store),
  .rsp_valid       (rsp_valid),
  .hazard_stalls   (hazard_stalls),
  .straddle_stalls (straddle_stalls),
  .span_error      (span_error),
  .load_mask       (load_mask)
);

// File: tb/test_xfer_stall_calc.sv
`timescale 1ns/1ps
module test_xfer_stall_calc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_is_store;
  logic [31:0] req_base;
  logic [3:0]  req_last;
  logic [15:0] mod_prev;
  logic [15:0] mod_prev2;
  logic        rsp_valid;
  logic [1:0]  hazard_stalls;
  logic [1:0]  straddle_stalls;
  logic        span_error;
  logic [15:0] load_mask;

  int n_run  = 0;
  int n_fail = 0;
  logic [1:0]  e_hz, e_st;
  logic        e_err;
  logic [15:0] e_mask;

  always #2 clk = ~clk;

  xfer_stall_calc i_xfer_stall_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_base(req_base), .req_last(req_last), .mod_prev(mod_prev), .mod_prev2(mod_prev2),
    .rsp_valid(rsp_valid), .hazard_stalls(hazard_stalls), .straddle_stalls(straddle_stalls),
    .span_error(span_error), .load_mask(load_mask)
  );

  function automatic logic [15:0] low_bits(input logic [3:0] l);
    logic [15:0] m = '0;
    for (int i = 0; i <= 15; i++) if (i <= int'(l)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic expect_calc(input logic st, input logic [31:0] b, input logic [3:0] l,
                             input logic [15:0] p, input logic [15:0] p2);
    logic [31:0] last_byte;
    logic [31:0] lines;
    logic [15:0] m;
    m = low_bits(l);
    last_byte = b + 32'((int'(l) + 1) * 4) - 32'd1;
    lines = (last_byte / 32) - (b / 32);
    e_err = lines > 32'd2;
    e_st  = e_err ? 2'd0 : lines[1:0];
    if (!st) e_hz = 2'd0;
    else if ((p & m) != 0) e_hz = 2'd2;
    else if ((p2 & m) != 0) e_hz = 2'd1;
    else e_hz = 2'd0;
    e_mask = st ? 16'd0 : m;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_fields(input string tag);
    chk({tag, " R3 R4 R5 hazard"}, 32'(hazard_stalls), 32'(e_hz));
    chk({tag, " R2 R7 straddle"}, 32'(straddle_stalls), 32'(e_st));
    chk({tag, " R8 span_error"}, 32'(span_error), 32'(e_err));
    chk({tag, " R6 load_mask"}, 32'(load_mask), 32'(e_mask));
  endtask

  // Called on a falling edge; returns on the falling edge one cycle later, after checking.
  task automatic send(input logic st, input logic [31:0] b, input logic [3:0] l,
                      input logic [15:0] p, input logic [15:0] p2);
    req_valid = 1'b1; req_is_store = st; req_base = b; req_last = l;
    mod_prev = p; mod_prev2 = p2;
    expect_calc(st, b, l, p, p2);
    @(negedge clk);
    chk("R1 rsp_valid after request", 32'(rsp_valid), 32'd1);
    check_fields("req");
    req_valid = 1'b0;
  endtask

  task automatic idle_hold();
    req_is_store = ~req_is_store; req_base = ~req_base; req_last = ~req_last;
    mod_prev = ~mod_prev; mod_prev2 = ~mod_prev2;
    @(negedge clk);
    chk("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    check_fields("R9 hold");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b0; req_base = '0;
    req_last = '0; mod_prev = '0; mod_prev2 = '0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    e_hz = 0; e_st = 0; e_err = 0; e_mask = 0;
    check_fields("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 one, two and three lines; R6 mask
    send(1'b0, 32'h0000_0000, 4'd7,  16'h0, 16'h0);
    send(1'b0, 32'h0000_0004, 4'd7,  16'h0, 16'h0);
    send(1'b0, 32'h0000_001C, 4'd15, 16'h0, 16'h0);
    idle_hold();
    send(1'b1, 32'h0000_0000, 4'd15, 16'h0, 16'h0);
    // R3, R4 priority and bits above L ignored
    send(1'b1, 32'h0000_0100, 4'd3, 16'h0008, 16'h0001);
    send(1'b1, 32'h0000_0100, 4'd3, 16'h0010, 16'h0001);
    send(1'b1, 32'h0000_0100, 4'd3, 16'hFFF0, 16'hFFF0);
    // R5 load ignores masks
    send(1'b0, 32'h0000_0040, 4'd15, 16'hFFFF, 16'hFFFF);
    // R7 both stall kinds together
    send(1'b1, 32'h0000_003C, 4'd15, 16'h0001, 16'h0000);
    idle_hold();
    // R8 wrap and top-of-space without wrap
    send(1'b1, 32'hFFFF_FFF0, 4'd7, 16'h0, 16'h0);
    idle_hold();
    send(1'b0, 32'hFFFF_FFE0, 4'd7, 16'h0, 16'h0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] b;
      b = $urandom() & 32'hFFFF_FFFC;
      if (k % 7 == 0) b = 32'hFFFF_FF80 | (b & 32'h7C);
      send(1'($urandom()), b, 4'($urandom()), 16'($urandom() & $urandom()),
           16'($urandom() & $urandom()));
      if (k % 9 == 0) idle_hold();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule